// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block is the interrupt control-register unit that sits beside a simple processor core. It watches a vector of level-sensitive interrupt lines, keeps an interrupt-enable mask and a status word whose lowest bit is the global interrupt enable, and raises a single registered interrupt request towards the core. Exception entry, dispatch and privilege checks stay in the core.

The core reaches the control registers through one write port (register index plus data) and one read port (register index plus the number of the destination general-purpose register). A read produces a registered write-back to the core one cycle later. The pending register is never stored. Its read value is computed from the synchronised lines ANDed with the enable mask. Writes to it are dropped.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Each interrupt line is level sensitive and passes through a two-flop synchroniser. A line's effect on the pending value follows its current level with no latching, and it reaches the request output three clock edges after the line changes.
- R2: A read of the pending register (index 4) returns the synchronised lines ANDed with the enable register (index 3), not the raw lines.
- R3: A write to the pending register (index 4) is ignored: the pending value, the enable register and the status register are unchanged afterwards.
- R4: The request output is high only when status bit 0 (global enable, status at index 0) is set and the lines ANDed with the enable register are nonzero.
- R5: After a write to the status or enable register, the request output reflects the new value one cycle after the write edge. It is not delayed further.
- R6: A read whose destination register number is 0 produces no write-back (write-back valid stays low).
- R7: A write to any other register index, including status and enable, stores the written 32-bit value unchanged, and a later read returns it.
- R8: After reset the enable register and the status register read as zero and the request output is low.
- R9: A read issued on one cycle returns its data, its destination number and write-back valid on the next cycle. A read and a write to the same index in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Raw level-sensitive interrupt lines |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_wr_idx | input | 5 | Index of the register written |
| cr_wr_data | input | 32 | Write data |
| cr_rd_en | input | 1 | Control-register read strobe |
| cr_rd_idx | input | 5 | Index of the register read |
| cr_rd_dest | input | 5 | Destination general register of the read |
| wb_valid | output | 1 | Write-back of a read is present |
| wb_dest | output | 5 | Destination register of the write-back |
| wb_data | output | 32 | Read data for the write-back |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
Each result has a fixed latency. A read's write-back is due one edge after the strobe. A status or enable write shows on the request one edge after the write edge. A line change reaches the pending read after two edges and the request after three. The bench drives inputs on falling edges and samples on later falling edges at those counts. It also checks the request one cycle before it is due, to confirm it is not early. Read results go through an expected-item queue that the monitor drains only when write-back valid rises, so a missing or extra write-back is caught as well as a wrong value.

// File: rtl/imask_pkg.sv
package imask_pkg;
  // Register indices decoded by the core's control-register instructions
  localparam int unsigned IDX_STATUS  = 0;
  localparam int unsigned IDX_ENABLE  = 3;
  localparam int unsigned IDX_PENDING = 4;
  // Global interrupt enable position inside the status word
  localparam int unsigned GIE_BIT     = 0;
endpackage

// File: rtl/imask_sync.sv
module imask_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/imask_cregs.sv
module imask_cregs
  import imask_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned N_IRQ  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  rd_dest,
  input  logic [N_IRQ-1:0]  masked,
  output logic              gie,
  output logic [N_IRQ-1:0]  enable,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_dest,
  output logic [DATA_W-1:0] wb_data
);
  localparam int unsigned NREG = 1 << IDX_W;

  logic [DATA_W-1:0] view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == IDX_PENDING) begin : g_pend
      // Computed view only, nothing stored, writes have no target
      assign view[g] = DATA_W'(masked);
    end else begin : g_store
      logic              ld;
      logic [DATA_W-1:0] q;
      assign ld = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= wr_data;
      end
      assign view[g] = q;
    end
  end

  assign gie    = view[IDX_STATUS][GIE_BIT];
  assign enable = view[IDX_ENABLE][N_IRQ-1:0];

  // Read stage: next-state then registers
  logic              wb_valid_d;
  logic [DATA_W-1:0] wb_data_d;

  always_comb begin
    wb_valid_d = rd_en && (rd_dest != '0);
    wb_data_d  = view[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_dest  <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= wb_valid_d;
      if (rd_en) begin
        wb_dest <= rd_dest;
        wb_data <= wb_data_d;
      end
    end
  end
endmodule

// File: rtl/imask_req.sv
module imask_req #(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] lines_sync,
  input  logic [N_IRQ-1:0] enable,
  input  logic             gie,
  output logic [N_IRQ-1:0] masked,
  output logic             irq_req
);
  logic req_d;

  always_comb begin
    masked = lines_sync & enable;
    req_d  = gie && (|masked);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= req_d;
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned N_IRQ  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_lines,
  input  logic              cr_wr_en,
  input  logic [IDX_W-1:0]  cr_wr_idx,
  input  logic [DATA_W-1:0] cr_wr_data,
  input  logic              cr_rd_en,
  input  logic [IDX_W-1:0]  cr_rd_idx,
  input  logic [IDX_W-1:0]  cr_rd_dest,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_dest,
  output logic [DATA_W-1:0] wb_data,
  output logic              irq_req
);
  logic [N_IRQ-1:0] lines_sync;
  logic [N_IRQ-1:0] masked;
  logic [N_IRQ-1:0] enable;
  logic             gie;

  imask_sync #(.WIDTH(N_IRQ)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_lines),
    .sync_out (lines_sync)
  );

  imask_cregs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .N_IRQ(N_IRQ)) u_cregs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cr_wr_en),
    .wr_idx   (cr_wr_idx),
    .wr_data  (cr_wr_data),
    .rd_en    (cr_rd_en),
    .rd_idx   (cr_rd_idx),
    .rd_dest  (cr_rd_dest),
    .masked   (masked),
    .gie      (gie),
    .enable   (enable),
    .wb_valid (wb_valid),
    .wb_dest  (wb_dest),
    .wb_data  (wb_data)
  );

  imask_req #(.N_IRQ(N_IRQ)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .lines_sync (lines_sync),
    .enable     (enable),
    .gie        (gie),
    .masked     (masked),
    .irq_req    (irq_req)
  );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk
  import imask_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned N_IRQ = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cr_wr_en,
  input logic [IDX_W-1:0] cr_wr_idx,
  input logic             cr_rd_en,
  input logic [IDX_W-1:0] cr_rd_dest,
  input logic             wb_valid,
  input logic             irq_req,
  input logic             gie,
  input logic [N_IRQ-1:0] enable,
  input logic [N_IRQ-1:0] lines_sync
);
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(gie)) else $error("request without global enable"); // R4

  AST_REQ_NEEDS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(|(lines_sync & enable))) else $error("request without enabled line"); // R2

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && (|(lines_sync & enable))) |=> irq_req) else $error("request late"); // R5

  AST_PEND_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_en && cr_wr_idx == IDX_W'(IDX_PENDING)) |=> ($stable(enable) && $stable(gie)))
    else $error("pending write had an effect"); // R3

  AST_ZERO_DEST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rd_en && cr_rd_dest == '0) |=> !wb_valid) else $error("write-back to zero register"); // R6

  AST_WB_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(cr_rd_en)) else $error("write-back without read"); // R9
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.IDX_W(IDX_W), .N_IRQ(N_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cr_wr_en   (cr_wr_en),
  .cr_wr_idx  (cr_wr_idx),
  .cr_rd_en   (cr_rd_en),
  .cr_rd_dest (cr_rd_dest),
  .wb_valid   (wb_valid),
  .irq_req    (irq_req),
  .gie        (gie),
  .enable     (enable),
  .lines_sync (lines_sync)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
  localparam int DW = 32;
  localparam int IW = 5;
  localparam int NI = 32;
  localparam logic [4:0] I_STAT = 5'd0;
  localparam logic [4:0] I_EN   = 5'd3;
  localparam logic [4:0] I_PEND = 5'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_lines = '0;
  logic          cr_wr_en = 1'b0;
  logic [IW-1:0] cr_wr_idx = '0;
  logic [DW-1:0] cr_wr_data = '0;
  logic          cr_rd_en = 1'b0;
  logic [IW-1:0] cr_rd_idx = '0;
  logic [IW-1:0] cr_rd_dest = '0;
  logic          wb_valid;
  logic [IW-1:0] wb_dest;
  logic [DW-1:0] wb_data;
  logic          irq_req;

  always #5 clk = ~clk;

  irq_mask_ctrl u_irq_mask_ctrl (.*);

  typedef struct {
    logic [IW-1:0] dest;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // Monitor: pops an expected item whenever a write-back appears
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 unexpected write-back: actual dest=%0d data=%h expected none", wb_dest, wb_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (wb_dest !== e.dest || wb_data !== e.data) begin
          n_fail++;
          $display("FAIL %s read: actual dest=%0d data=%h expected dest=%0d data=%h",
                   e.req, wb_dest, wb_data, e.dest, e.data);
        end
      end
    end
  end

  task automatic wr(input logic [IW-1:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    cr_wr_en = 1'b1; cr_wr_idx = idx; cr_wr_data = d;
    @(negedge clk);
    cr_wr_en = 1'b0;
  endtask

  // Driver: pushes the expected write-back, then issues the read
  task automatic rd(input logic [IW-1:0] idx, input logic [IW-1:0] dest,
                    input logic [DW-1:0] exp_d, input string req);
    @(negedge clk);
    if (dest != '0) begin
      exp_t e;
      e.dest = dest; e.data = exp_d; e.req = req;
      exp_q.push_back(e);
    end
    cr_rd_en = 1'b1; cr_rd_idx = idx; cr_rd_dest = dest;
    @(negedge clk);
    cr_rd_en = 1'b0;
    if (dest == '0) begin
      n_vec++;
      if (wb_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R6 zero-dest read: actual wb_valid=%b expected 0", wb_valid);
      end
    end
  endtask

  task automatic chk_irq(input logic exp_v, input string req);
    n_vec++;
    if (irq_req !== exp_v) begin
      n_fail++;
      $display("FAIL %s irq_req: actual %b expected %b", req, irq_req, exp_v);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk_irq(1'b0, "R8");
    rd(I_EN,   5'd1, 32'h0, "R8");
    rd(I_STAT, 5'd2, 32'h0, "R8");

    // R7 generic register store and read-back
    wr(5'd7, 32'hA5A5_5A5A);
    rd(5'd7, 5'd3, 32'hA5A5_5A5A, "R7");
    wr(5'd31, 32'h0123_4567);
    rd(5'd31, 5'd4, 32'h0123_4567, "R7");

    // R2 pending with enable clear reads zero, R4 no request
    irq_lines = 32'hF0F0_000F;
    settle(3);
    rd(I_PEND, 5'd5, 32'h0, "R2");
    chk_irq(1'b0, "R4");

    // R2 mask applied, R4 global enable still clear
    wr(I_EN, 32'h0000_0003);
    rd(I_PEND, 5'd6, 32'h0000_0003, "R2");
    rd(I_EN,   5'd7, 32'h0000_0003, "R7");
    settle(1);
    chk_irq(1'b0, "R4");

    // R5 status write: request one cycle after the write edge
    wr(I_STAT, 32'h0000_0001);
    chk_irq(1'b0, "R5");
    @(negedge clk);
    chk_irq(1'b1, "R5");

    // R3 pending write ignored
    wr(I_PEND, 32'hFFFF_FFFF);
    rd(I_PEND, 5'd8, 32'h0000_0003, "R3");
    rd(I_EN,   5'd9, 32'h0000_0003, "R3");
    rd(I_STAT, 5'd10, 32'h0000_0001, "R3");
    chk_irq(1'b1, "R3");

    // R1 level sensitive: drop lines, request falls on the third edge
    @(negedge clk);
    irq_lines = 32'hF0F0_0000;
    @(negedge clk); @(negedge clk);
    chk_irq(1'b1, "R1");
    @(negedge clk);
    chk_irq(1'b0, "R1");
    rd(I_PEND, 5'd11, 32'h0, "R1");
    // raise again: no latching either way
    irq_lines = 32'h0000_0002;
    settle(3);
    chk_irq(1'b1, "R1");
    rd(I_PEND, 5'd12, 32'h0000_0002, "R1");

    // R5 enable write removes the request one cycle after the write edge
    wr(I_EN, 32'h0000_0001);
    chk_irq(1'b1, "R5");
    @(negedge clk);
    chk_irq(1'b0, "R5");
    rd(I_PEND, 5'd13, 32'h0, "R2");

    // R4 status with other bits but global enable clear
    wr(I_EN, 32'hFFFF_FFFF);
    wr(I_STAT, 32'h8000_0000);
    settle(1);
    chk_irq(1'b0, "R4");
    rd(I_STAT, 5'd14, 32'h8000_0000, "R7");
    rd(I_PEND, 5'd15, 32'h0000_0002, "R2");

    // R6 zero-destination reads produce nothing
    rd(I_STAT, 5'd0, 32'h0, "R6");
    rd(I_PEND, 5'd0, 32'h0, "R6");

    // R9 read and write to the same index in one cycle return the old value
    @(negedge clk);
    begin
      exp_t e;
      e.dest = 5'd16; e.data = 32'hA5A5_5A5A; e.req = "R9";
      exp_q.push_back(e);
    end
    cr_wr_en = 1'b1; cr_wr_idx = 5'd7; cr_wr_data = 32'h1111_2222;
    cr_rd_en = 1'b1; cr_rd_idx = 5'd7; cr_rd_dest = 5'd16;
    @(negedge clk);
    cr_wr_en = 1'b0; cr_rd_en = 1'b0;
    rd(5'd7, 5'd17, 32'h1111_2222, "R9");

    settle(3);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 missing write-backs: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule